// File: doc/BRIEF.md
# Strobe-Synchronized Host Register Bus Slave

This block sits between a host processor and a set of internal registers, some of which are fed by shift buffers. The host raises a strobe with a read/write select, an address and, for writes, data. It does not need to know the phase of the local serial clock. The block samples the strobe on each falling edge of that clock through a synchronizer. Each low-to-high strobe change becomes one capture event. That event turns into a one-clock read or write pulse towards the register side.

Reads and writes each have their own address/data latch and control. A write can still be waiting for its buffer, or still in flight, while a read is captured and serviced, and the reverse also holds. Mixed read/write traffic can therefore be accepted on consecutive clocks. A strobe that arrives just too late for a falling edge is taken on the following edge, which costs exactly one clock.

A ready output handshakes with the host. It drops while a latch path holds an access that its buffer cannot take yet, or holds a strobe that arrived while that path was busy. Such a strobe is remembered, not lost.

Top module: `strobe_bus_slave`

## Requirements
- R1: `host_stb` is sampled on every falling `clk` edge through two flip-flops. A low-to-high change first sampled high at falling edge k becomes one capture event, acted on at falling edge k+2.
- R2: A strobe that rises just after falling edge k, and not just before it, is first sampled at edge k+1. Its capture and every later step occur exactly one clock later.
- R3: When a write is captured (`host_rnw`=0) and `wr_buf_ok` is 1, `wr_pulse` is high for exactly the one clock after the capture edge. `wr_addr`/`wr_data` then show `host_addr`/`host_wdata` as sampled at that edge.
- R4: When a read is captured (`host_rnw`=1) and `rd_buf_ok` is 1, `rd_pulse` is high for the one clock after the capture edge, with `rd_addr` equal to the host address. At the next falling edge `rd_data_in` is loaded into `host_rdata`, which changes at no other time.
- R5: A captured access whose buffer-ok input is 0 stays pending with its address held. Its pulse is issued at the first falling edge at which that ok input is 1.
- R6: `host_rdy` is 0 while either path has a pending access or a deferred strobe, and 1 otherwise.
- R7: A capture event for a path that is already pending is deferred, not dropped. It is accepted on the edge after that path's pulse, using the host bus values present then.
- R8: The read and write paths are independent: an access pending on one path does not delay a capture or a pulse on the other.
- R9: A synchronous active-high `rst` clears the synchronizer, both latch paths (addresses and data to 0, no pulse) and `host_rdy`. `host_rdy` rises at the first falling edge after reset is released.
- R10: A strobe held high for many clocks produces exactly one capture event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| host_stb | input | 1 | Host strobe, asynchronous, active high |
| host_rnw | input | 1 | 1 = read, 0 = write; stable while the strobe is high |
| host_addr | input | AW | Host register address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data latch toward the host |
| host_rdy | output | 1 | Handshake: 0 while an access is pending or deferred |
| wr_buf_ok | input | 1 | Write-side buffer can accept data |
| rd_buf_ok | input | 1 | Read-side buffer can supply data |
| wr_pulse | output | 1 | One-clock internal write command |
| wr_addr | output | AW | Latched write address |
| wr_data | output | DW | Latched write data |
| rd_pulse | output | 1 | One-clock internal read command |
| rd_addr | output | AW | Latched read address |
| rd_data_in | input | DW | Register-side read data for `rd_addr` |

## Verification
A corrupted synchronizer or edge detector shows at the ports as a pulse two clocks early or late, or as a second pulse under one long strobe. The reference model flags either at the first posedge sample after the wrong falling edge. A stuck pending or deferred flag keeps `host_rdy` low or drops a queued write, and `host_rdy`, `wr_addr` and the pulse lines diverge from the model within one clock of the buffer becoming ready. A read latch loaded at the wrong time makes `host_rdata` change outside the clock after `rd_pulse`, and this is caught on that same sample.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Which side of the bus a latch path serves.
    typedef enum logic {
        PATH_WR = 1'b0,
        PATH_RD = 1'b1
    } path_kind_e;

endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    localparam int DEPTH = STAGES + 1;   // synchronizer stages plus one history bit

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], async_i};
    end

    always_ff @(negedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R10: a level held high yields a single event
    a_r10_single_rise: assert property (@(negedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/sbs_path.sv
module sbs_path
    import sbs_pkg::*;
#(
    parameter int         AW   = 4,
    parameter int         DW   = 8,
    parameter path_kind_e KIND = PATH_WR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] late_i,
    input  logic          go_ok_i,
    output logic          pulse_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          busy_nx_o,
    output logic          hold_o
);
    // Read paths load data after issuing their pulse; write paths at capture.
    localparam bit LATE = (KIND == PATH_RD);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          pend;
        logic          defer;
        logic          pulse;
    } st_t;

    st_t  s_d, s_q;
    logic take;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        take      = (start_i | s_q.defer) & ~s_q.pend;

        if (LATE && s_q.pulse) s_d.data = late_i;

        if (s_q.pend && go_ok_i) begin
            s_d.pend  = 1'b0;
            s_d.pulse = 1'b1;
        end

        if (start_i && s_q.pend) s_d.defer = 1'b1;

        if (take) begin
            s_d.addr  = addr_i;
            if (!LATE) s_d.data = wdata_i;
            s_d.defer = 1'b0;
            s_d.pulse = go_ok_i;
            s_d.pend  = ~go_ok_i;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign pulse_o   = s_q.pulse;
    assign addr_o    = s_q.addr;
    assign data_o    = s_q.data;
    assign busy_nx_o = s_d.pend | s_d.defer;
    assign hold_o    = s_q.pend | s_q.defer;

    // R5: a pulse is only issued while the buffer reported ready
    a_r5_pulse_needs_ok: assert property (@(negedge clk) disable iff (rst)
        pulse_o |-> $past(go_ok_i));

    // R5: a waiting access keeps its address
    a_r5_addr_held: assert property (@(negedge clk) disable iff (rst)
        (s_q.pend && $past(s_q.pend)) |-> $stable(s_q.addr));

endmodule

// File: rtl/strobe_bus_slave.sv
module strobe_bus_slave
    import sbs_pkg::*;
#(
    parameter int AW          = 4,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_stb,
    input  logic          host_rnw,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rdy,
    input  logic          wr_buf_ok,
    input  logic          rd_buf_ok,
    output logic          wr_pulse,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_pulse,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data_in
);
    typedef struct packed {
        logic rdy;
    } top_st_t;

    top_st_t t_d, t_q;

    logic          rise;
    logic          wr_busy_nx, rd_busy_nx;
    logic          wr_hold, rd_hold;
    logic [DW-1:0] wr_unused_late;
    logic [AW-1:0] rd_addr_w;
    logic [DW-1:0] rd_data_w;

    assign wr_unused_late = '0;

    sbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (host_stb),
        .rise_o  (rise)
    );

    sbs_path #(.AW(AW), .DW(DW), .KIND(PATH_WR)) u_wr (
        .clk       (clk),
        .rst       (rst),
        .start_i   (rise & ~host_rnw),
        .addr_i    (host_addr),
        .wdata_i   (host_wdata),
        .late_i    (wr_unused_late),
        .go_ok_i   (wr_buf_ok),
        .pulse_o   (wr_pulse),
        .addr_o    (wr_addr),
        .data_o    (wr_data),
        .busy_nx_o (wr_busy_nx),
        .hold_o    (wr_hold)
    );

    sbs_path #(.AW(AW), .DW(DW), .KIND(PATH_RD)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .start_i   (rise & host_rnw),
        .addr_i    (host_addr),
        .wdata_i   (host_wdata),
        .late_i    (rd_data_in),
        .go_ok_i   (rd_buf_ok),
        .pulse_o   (rd_pulse),
        .addr_o    (rd_addr_w),
        .data_o    (rd_data_w),
        .busy_nx_o (rd_busy_nx),
        .hold_o    (rd_hold)
    );

    always_comb begin
        t_d     = t_q;
        t_d.rdy = ~(wr_busy_nx | rd_busy_nx);
    end

    always_ff @(negedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign host_rdy   = t_q.rdy;
    assign rd_addr    = rd_addr_w;
    assign host_rdata = rd_data_w;

    // R6: handshake low whenever a path holds work
    a_r6_rdy_low_when_held: assert property (@(negedge clk) disable iff (rst)
        (wr_hold | rd_hold) |-> !host_rdy);

    // R4: read latch only moves on the edge after a read pulse
    a_r4_rdata_only_after_pulse: assert property (@(negedge clk) disable iff (rst)
        !$past(rd_pulse) |-> $stable(host_rdata));

endmodule

// File: tb/strobe_bus_slave_test.sv
module strobe_bus_slave_test;
    localparam int AW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_stb = 1'b0, host_rnw = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          wr_buf_ok = 1'b1, rd_buf_ok = 1'b1;
    logic [DW-1:0] host_rdata, wr_data, rd_data_in;
    logic [AW-1:0] wr_addr, rd_addr;
    logic          host_rdy, wr_pulse, rd_pulse;

    int checks = 0, errors = 0, cyc = 0;
    int wcnt = 0, rcnt = 0;
    bit cmp_en = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    assign rd_data_in = {rd_addr, ~rd_addr};

    strobe_bus_slave #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst(rst), .host_stb(host_stb), .host_rnw(host_rnw),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rdy(host_rdy), .wr_buf_ok(wr_buf_ok), .rd_buf_ok(rd_buf_ok),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_pulse(rd_pulse), .rd_addr(rd_addr), .rd_data_in(rd_data_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic          m_hist [3];
    logic [AW-1:0] m_addr [2];
    logic [DW-1:0] m_data [2];
    bit            m_pend [2], m_def [2], m_pul [2];
    logic          m_rdy;

    always @(negedge clk) begin
        bit rise;
        if (rst) begin
            for (int i = 0; i < 3; i++) m_hist[i] = 1'b0;
            for (int p = 0; p < 2; p++) begin
                m_addr[p] = '0; m_data[p] = '0;
                m_pend[p] = 0; m_def[p] = 0; m_pul[p] = 0;
            end
            m_rdy = 1'b0;
        end else begin
            rise = m_hist[1] && !m_hist[2];
            for (int p = 0; p < 2; p++) begin
                bit st, ok, tk, was_pend;
                st       = rise && (host_rnw == p[0]);
                ok       = (p == 1) ? rd_buf_ok : wr_buf_ok;
                was_pend = m_pend[p];
                tk       = (st || m_def[p]) && !was_pend;
                if (p == 1 && m_pul[1]) m_data[1] = {m_addr[1], ~m_addr[1]};
                m_pul[p] = 0;
                if (was_pend && ok) begin m_pend[p] = 0; m_pul[p] = 1; end
                if (st && was_pend) m_def[p] = 1;
                if (tk) begin
                    m_addr[p] = host_addr;
                    if (p == 0) m_data[0] = host_wdata;
                    m_def[p]  = 0;
                    m_pul[p]  = ok;
                    m_pend[p] = !ok;
                end
            end
            m_hist[2] = m_hist[1]; m_hist[1] = m_hist[0]; m_hist[0] = host_stb;
            m_rdy = !(m_pend[0] || m_pend[1] || m_def[0] || m_def[1]);
        end
    end

    // per-clock comparison, away from the falling (active) edge
    always @(posedge clk) begin
        if (cmp_en) begin
            chk("R3 wr_pulse", wr_pulse, m_pul[0]);
            chk("R3 wr_addr", wr_addr, m_addr[0]);
            chk("R3 wr_data", wr_data, m_data[0]);
            chk("R4 rd_pulse", rd_pulse, m_pul[1]);
            chk("R4 rd_addr", rd_addr, m_addr[1]);
            chk("R4 host_rdata", host_rdata, m_data[1]);
            chk("R6 host_rdy", host_rdy, m_rdy);
        end
        if (!rst) begin
            if (wr_pulse) wcnt++;
            if (rd_pulse) rcnt++;
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog (all requirements) act=%0d exp=<150000", cyc);
            finish_run();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic drive(input logic rnw, input logic [AW-1:0] a, input logic [DW-1:0] d);
        host_rnw = rnw; host_addr = a; host_wdata = d; host_stb = 1'b1;
    endtask

    // Falling edges from reference edge E until the given pulse is seen.
    task automatic latency(input bit late, input bit rd, output int n);
        if (late) begin
            @(negedge clk); #1; n = 1;
        end else begin
            @(posedge clk); n = 0;
        end
        drive(rd, 4'h6 - 4'(late), 8'h5A);
        do begin
            @(negedge clk); n++;
            @(posedge clk);
        end while (!(rd ? rd_pulse : wr_pulse) && n < 12);
    endtask

    initial begin
        int n, w0, r0;
        idle(1);
        cmp_en = 1'b1;
        idle(2);
        // R9: reset state
        chk("R9 rdy in reset", host_rdy, 1'b0);
        chk("R9 wr_pulse in reset", wr_pulse, 1'b0);
        chk("R9 rd_pulse in reset", rd_pulse, 1'b0);
        chk("R9 rdata in reset", host_rdata, '0);
        rst = 1'b0;
        idle(2);
        chk("R9 rdy after release", host_rdy, 1'b1);

        // R1 / R3 / R10: early write, held long
        w0 = wcnt;
        latency(1'b0, 1'b0, n);
        chk("R1 early write latency", n, 3);
        chk("R3 wr_addr at pulse", wr_addr, 4'h6);
        chk("R3 wr_data at pulse", wr_data, 8'h5A);
        idle(8);
        chk("R10 one pulse for long strobe", wcnt - w0, 1);
        host_stb = 1'b0; idle(4);

        // R2: late strobe costs one clock
        latency(1'b1, 1'b0, n);
        chk("R2 late write latency", n, 4);
        @(posedge clk); host_stb = 1'b0; idle(4);

        // R4: read and data return
        latency(1'b0, 1'b1, n);
        chk("R4 read latency", n, 3);
        idle(1);
        chk("R4 read data loaded", host_rdata, {4'h6, 4'h9});
        host_stb = 1'b0; idle(4);

        // R8 / R5 / R6 / R7: write blocked, read overtakes, deferred write
        wr_buf_ok = 1'b0;
        w0 = wcnt; r0 = rcnt;
        drive(1'b0, 4'hA, 8'hC3); idle(2); host_stb = 1'b0; idle(4);
        chk("R6 rdy low while write pending", host_rdy, 1'b0);
        drive(1'b1, 4'h2, 8'h00); idle(2); host_stb = 1'b0; idle(4);
        chk("R8 read served past blocked write", rcnt - r0, 1);
        chk("R8 read data", host_rdata, {4'h2, 4'hD});
        chk("R5 no write pulse while not ok", wcnt - w0, 0);
        chk("R5 write address held", wr_addr, 4'hA);
        drive(1'b0, 4'hB, 8'h7E); idle(5);
        wr_buf_ok = 1'b1; idle(6);
        chk("R7 deferred write executed", wcnt - w0, 2);
        chk("R7 deferred address", wr_addr, 4'hB);
        chk("R7 deferred data", wr_data, 8'h7E);
        chk("R6 rdy back", host_rdy, 1'b1);
        host_stb = 1'b0; idle(4);

        // read side blocked, write overtakes
        rd_buf_ok = 1'b0; w0 = wcnt;
        drive(1'b1, 4'h4, 8'h00); idle(2); host_stb = 1'b0; idle(3);
        drive(1'b0, 4'h9, 8'h11); idle(2); host_stb = 1'b0; idle(4);
        chk("R8 write served past blocked read", wcnt - w0, 1);
        rd_buf_ok = 1'b1; idle(4);

        // mixed random traffic against the model
        for (int i = 0; i < 300; i++) begin
            @(posedge clk);
            wr_buf_ok = ($urandom_range(3) != 0);
            rd_buf_ok = ($urandom_range(3) != 0);
            drive(1'($urandom_range(1)), 4'($urandom), 8'($urandom));
            idle($urandom_range(3));
            @(posedge clk); host_stb = 1'b0;
            idle($urandom_range(2));
        end
        wr_buf_ok = 1'b1; rd_buf_ok = 1'b1;
        idle(10);
        chk("R6 idle at end", host_rdy, 1'b1);
        finish_run();
    end
endmodule